// File: doc/BRIEF.md
# Flash Readout Protection Level Controller

This block holds the active readout-protection level of an embedded flash and rules on every access to the flash array, the backup registers and the option-byte area. The level comes from a stored protection byte and its stored complement. A matched pair with the open code gives the unprotected level (0). A matched pair with the lock code gives the irreversible top level (2). Every other pair, including an erased byte or a bad complement, gives the middle level (1), so the decode denies by default.

Each access request is judged against the active level and the current execution mode. The block returns a registered grant or a set of error flags one cycle later. At level 1, the debug, boot-from-RAM and boot-loader modes lose all access to the flash and the backup registers. At level 2 those modes are switched off altogether. Writing the open code into the protection byte lowers the protection, so the block issues a mass-erase pulse, plus a backup-clear pulse when the level being left is 1. It then refuses further option-byte writes until the erase reports done. A level that has been written takes effect only when the option-reload pulse arrives.

Top module: `readout_guard`

## Requirements
- R1: On a reload pulse the level becomes 0 for byte 0xAA with complement 0x55, 2 for byte 0xCC with complement 0x33, and 1 for any other pair. The level_o encoding is 0, 1 or 2.
- R2: After reset the level is 1 until the first reload pulse.
- R3: The level changes only on a reload pulse, whatever the option inputs do between pulses.
- R4: At level 1, in mode 1 (debug), 2 (boot RAM) or 3 (boot loader), a request to target 0 (flash) or target 1 (backup) gives bus_err_o and fault_o high and grant_o low in the next cycle.
- R5: In the R4 case, a program or erase to target 0 also raises prog_err_o.
- R6: In mode 0 (user) at levels 0 and 1, every read, program and erase on targets 0 and 1 is granted with no error flag.
- R7: At level 2, debug_off_o is high and every mode is treated as user, so flash and backup accesses are granted.
- R8: At level 2, an erase of target 2 (option bytes) and a program with req_prot_i high (the protection byte) are refused with wprot_err_o. Option reads and programs of other option bytes are granted.
- R9: At level 0 or 1, a granted program of 0xAA into the protection byte gives a one-cycle mass_erase_o pulse. bkp_clear_o pulses with it only when the level is 1.
- R10: From a mass-erase pulse until erase_done_i, erase_busy_o is high and option-byte programs and erases are refused with no flag and no erase pulse. Option reads stay granted.
- R11: At level 0 or 1, programming any value other than 0xAA into the protection byte is granted with no erase pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| opt_val_i | input | 8 | Latched protection byte |
| opt_cmp_i | input | 8 | Latched complement of the protection byte |
| reload_i | input | 1 | Option-reload pulse that loads the decoded level |
| mode_i | input | 2 | Execution mode: 0 user, 1 debug, 2 boot RAM, 3 boot loader |
| req_valid_i | input | 1 | Access request present this cycle |
| req_tgt_i | input | 2 | Target: 0 flash, 1 backup registers, 2 option bytes, 3 other |
| req_rd_i | input | 1 | Read strobe |
| req_pg_i | input | 1 | Program strobe |
| req_er_i | input | 1 | Erase strobe (has priority over program, which has priority over read) |
| req_prot_i | input | 1 | Option program addresses the protection byte |
| req_wdata_i | input | 8 | Value being programmed |
| erase_done_i | input | 1 | Mass erase finished |
| grant_o | output | 1 | Previous request allowed |
| bus_err_o | output | 1 | Previous request ended in a bus error |
| fault_o | output | 1 | Fault indication for the processor |
| prog_err_o | output | 1 | Programming error flag pulse |
| wprot_err_o | output | 1 | Write-protection error flag pulse |
| mass_erase_o | output | 1 | One-cycle mass-erase trigger |
| bkp_clear_o | output | 1 | One-cycle backup-register reset trigger |
| erase_busy_o | output | 1 | Mass erase outstanding |
| debug_off_o | output | 1 | Debug and alternate boot modes disabled |
| level_o | output | 2 | Active protection level |

## Verification
The bench aims at the decode edges: the right byte with a wrong complement, and an erased byte. A default-allow decode would report level 0 there and drop all protection. It writes option bytes without a reload to catch a design that applies new values at once. It lowers protection from level 0 and from level 1, because a design that clears the backup registers on both paths would wipe them needlessly, and one that clears on neither would leak their contents. It issues option writes while an erase is outstanding, where a design that does not wait would restart or overlap erases.

// File: rtl/rguard_pkg.sv
package rguard_pkg;

  typedef enum logic [1:0] {
    LVL_OPEN = 2'd0,
    LVL_READ = 2'd1,
    LVL_LOCK = 2'd2
  } lvl_t;

  typedef enum logic [1:0] {
    M_USER  = 2'd0,
    M_DEBUG = 2'd1,
    M_BRAM  = 2'd2,
    M_BLDR  = 2'd3
  } mode_t;

  typedef enum logic [1:0] {
    T_FLASH = 2'd0,
    T_BKP   = 2'd1,
    T_OPT   = 2'd2,
    T_OTHER = 2'd3
  } tgt_t;

  typedef struct packed {
    logic grant;
    logic berr;
    logic pgerr;
    logic wperr;
    logic erase;
    logic bkp;
  } verdict_t;

  // Lock level removes the alternate modes entirely.
  function automatic mode_t effective_mode(lvl_t lvl, mode_t m);
    return (lvl == LVL_LOCK) ? M_USER : m;
  endfunction

  // Restricted: middle level while not running user code.
  function automatic logic is_restricted(lvl_t lvl, mode_t m);
    return (lvl == LVL_READ) && (effective_mode(lvl, m) != M_USER);
  endfunction

endpackage

// File: rtl/rguard_level.sv
module rguard_level
  import rguard_pkg::*;
#(
  parameter int          BYTE_W    = 8,
  parameter logic [BYTE_W-1:0] OPEN_CODE = 8'hAA,
  parameter logic [BYTE_W-1:0] LOCK_CODE = 8'hCC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reload,
  input  logic [BYTE_W-1:0] opt_val,
  input  logic [BYTE_W-1:0] opt_cmp,
  output lvl_t              level
);

  function automatic lvl_t decode_pair(logic [BYTE_W-1:0] v, logic [BYTE_W-1:0] c);
    logic pair_ok;
    pair_ok = (c == ~v);
    if (pair_ok && v == OPEN_CODE)      return LVL_OPEN;
    else if (pair_ok && v == LOCK_CODE) return LVL_LOCK;
    else                                return LVL_READ;
  endfunction

  lvl_t decoded;
  assign decoded = decode_pair(opt_val, opt_cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      level <= LVL_READ;
    else if (reload) level <= decoded;
  end

endmodule

// File: rtl/rguard_policy.sv
module rguard_policy
  import rguard_pkg::*;
#(
  parameter int          BYTE_W    = 8,
  parameter logic [BYTE_W-1:0] OPEN_CODE = 8'hAA
) (
  input  lvl_t              level,
  input  logic              busy,
  input  mode_t             mode,
  input  logic              req_valid,
  input  tgt_t              req_tgt,
  input  logic              req_rd,
  input  logic              req_pg,
  input  logic              req_er,
  input  logic              req_prot,
  input  logic [BYTE_W-1:0] req_wdata,
  output verdict_t          verdict
);

  logic restr;
  logic is_wr;
  logic locked;
  logic rd_unused;

  assign restr     = is_restricted(level, mode);
  assign is_wr     = req_pg | req_er;
  assign locked    = (level == LVL_LOCK);
  assign rd_unused = req_rd;

  always_comb begin
    verdict = '0;
    if (req_valid) begin
      unique case (req_tgt)
        T_FLASH, T_BKP: begin
          if (restr) begin
            verdict.berr  = 1'b1;
            verdict.pgerr = (req_tgt == T_FLASH) && is_wr;
          end else begin
            verdict.grant = 1'b1;
          end
        end
        T_OPT: begin
          if (req_er) begin
            if (locked)     verdict.wperr = 1'b1;
            else if (!busy) verdict.grant = 1'b1;
          end else if (req_pg) begin
            if (locked && req_prot) verdict.wperr = 1'b1;
            else if (!busy) begin
              verdict.grant = 1'b1;
              if (req_prot && !locked && req_wdata == OPEN_CODE) begin
                verdict.erase = 1'b1;
                verdict.bkp   = (level == LVL_READ);
              end
            end
          end else begin
            verdict.grant = 1'b1 | rd_unused;
          end
        end
        default: verdict.grant = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/rguard_seq.sv
module rguard_seq
  import rguard_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  verdict_t verdict,
  input  logic     erase_done,
  output logic     grant,
  output logic     bus_err,
  output logic     fault,
  output logic     prog_err,
  output logic     wprot_err,
  output logic     mass_erase,
  output logic     bkp_clear,
  output logic     busy
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant      <= 1'b0;
      bus_err    <= 1'b0;
      fault      <= 1'b0;
      prog_err   <= 1'b0;
      wprot_err  <= 1'b0;
      mass_erase <= 1'b0;
      bkp_clear  <= 1'b0;
      busy       <= 1'b0;
    end else begin
      grant      <= verdict.grant;
      bus_err    <= verdict.berr;
      fault      <= verdict.berr;
      prog_err   <= verdict.pgerr;
      wprot_err  <= verdict.wperr;
      mass_erase <= verdict.erase;
      bkp_clear  <= verdict.bkp;
      if (verdict.erase)   busy <= 1'b1;
      else if (erase_done) busy <= 1'b0;
    end
  end

endmodule

// File: rtl/readout_guard.sv
module readout_guard
  import rguard_pkg::*;
#(
  parameter int          BYTE_W    = 8,
  parameter logic [BYTE_W-1:0] OPEN_CODE = 8'hAA,
  parameter logic [BYTE_W-1:0] LOCK_CODE = 8'hCC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] opt_val_i,
  input  logic [BYTE_W-1:0] opt_cmp_i,
  input  logic              reload_i,
  input  logic [1:0]        mode_i,
  input  logic              req_valid_i,
  input  logic [1:0]        req_tgt_i,
  input  logic              req_rd_i,
  input  logic              req_pg_i,
  input  logic              req_er_i,
  input  logic              req_prot_i,
  input  logic [BYTE_W-1:0] req_wdata_i,
  input  logic              erase_done_i,
  output logic              grant_o,
  output logic              bus_err_o,
  output logic              fault_o,
  output logic              prog_err_o,
  output logic              wprot_err_o,
  output logic              mass_erase_o,
  output logic              bkp_clear_o,
  output logic              erase_busy_o,
  output logic              debug_off_o,
  output logic [1:0]        level_o
);

  lvl_t     level;
  verdict_t verdict;

  rguard_level #(.BYTE_W(BYTE_W), .OPEN_CODE(OPEN_CODE), .LOCK_CODE(LOCK_CODE)) u_level (
    .clk     (clk),
    .rst_n   (rst_n),
    .reload  (reload_i),
    .opt_val (opt_val_i),
    .opt_cmp (opt_cmp_i),
    .level   (level)
  );

  rguard_policy #(.BYTE_W(BYTE_W), .OPEN_CODE(OPEN_CODE)) u_policy (
    .level     (level),
    .busy      (erase_busy_o),
    .mode      (mode_t'(mode_i)),
    .req_valid (req_valid_i),
    .req_tgt   (tgt_t'(req_tgt_i)),
    .req_rd    (req_rd_i),
    .req_pg    (req_pg_i),
    .req_er    (req_er_i),
    .req_prot  (req_prot_i),
    .req_wdata (req_wdata_i),
    .verdict   (verdict)
  );

  rguard_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .verdict    (verdict),
    .erase_done (erase_done_i),
    .grant      (grant_o),
    .bus_err    (bus_err_o),
    .fault      (fault_o),
    .prog_err   (prog_err_o),
    .wprot_err  (wprot_err_o),
    .mass_erase (mass_erase_o),
    .bkp_clear  (bkp_clear_o),
    .busy       (erase_busy_o)
  );

  assign level_o     = level;
  assign debug_off_o = (level == LVL_LOCK);

endmodule

// File: rtl/rguard_chk.sv
module rguard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reload_i,
  input logic       req_valid_i,
  input logic [1:0] req_tgt_i,
  input logic       req_pg_i,
  input logic       req_er_i,
  input logic       grant_o,
  input logic       bus_err_o,
  input logic       fault_o,
  input logic       prog_err_o,
  input logic       mass_erase_o,
  input logic       bkp_clear_o,
  input logic       erase_busy_o,
  input logic [1:0] level_o
);

  p_level_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !reload_i |=> $stable(level_o));

  p_deny_on_berr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err_o |-> (!grant_o && fault_o));

  p_pgerr_restricted_r5: assert property (@(posedge clk) disable iff (!rst_n)
    prog_err_o |-> bus_err_o);

  p_lock_flash_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o == 2'd2 && !reload_i && req_valid_i && req_tgt_i == 2'd0) |=> grant_o);

  p_erase_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mass_erase_o |=> !mass_erase_o);

  p_bkp_with_erase_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bkp_clear_o |-> mass_erase_o);

  p_busy_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_busy_o && req_valid_i && req_tgt_i == 2'd2 && (req_pg_i || req_er_i))
      |=> (!grant_o && !mass_erase_o));

endmodule

bind readout_guard rguard_chk u_chk (.*);

// File: tb/readout_guard_tb.sv
module readout_guard_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] opt_val = 8'hFF, opt_cmp = 8'hFF, wdata = 8'h00;
  logic       reload = 1'b0, valid = 1'b0, rd = 1'b0, pg = 1'b0, er = 1'b0, prot = 1'b0, done = 1'b0;
  logic [1:0] mode = 2'd0, tgt = 2'd0;
  logic grant, berr, fault, pgerr, wperr, merase, bclr, busy, dbg_off;
  logic [1:0] level;

  int checks = 0, errors = 0;
  int m_level = 1;
  bit m_busy = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  readout_guard dut_i (
    .clk(clk), .rst_n(rst_n), .opt_val_i(opt_val), .opt_cmp_i(opt_cmp), .reload_i(reload),
    .mode_i(mode), .req_valid_i(valid), .req_tgt_i(tgt), .req_rd_i(rd), .req_pg_i(pg),
    .req_er_i(er), .req_prot_i(prot), .req_wdata_i(wdata), .erase_done_i(done),
    .grant_o(grant), .bus_err_o(berr), .fault_o(fault), .prog_err_o(pgerr),
    .wprot_err_o(wperr), .mass_erase_o(merase), .bkp_clear_o(bclr),
    .erase_busy_o(busy), .debug_off_o(dbg_off), .level_o(level)
  );

  function automatic int ref_level(logic [7:0] v, logic [7:0] c);
    if ((v ^ c) != 8'hFF) return 1;
    if (v == 8'hAA) return 0;
    if (v == 8'hCC) return 2;
    return 1;
  endfunction

  // expected {grant,berr,fault,pgerr,wperr,erase,bkp}; op: 0 rd,1 pg,2 er
  function automatic logic [6:0] ref_out(int lv, bit bz, int md, int tg, int op, bit pr, logic [7:0] wd);
    bit alt;
    alt = (lv == 1) && (md != 0);
    if (tg == 0 || tg == 1) begin
      if (alt) return {1'b0, 1'b1, 1'b1, (tg == 0 && op != 0), 3'b000};
      return 7'b1000000;
    end
    if (tg == 2) begin
      if (op == 0) return 7'b1000000;
      if (lv == 2 && (op == 2 || pr)) return 7'b0000100;
      if (bz) return 7'b0000000;
      if (op == 1 && pr && wd == 8'hAA) return {5'b10000, 1'b1, (lv == 1)};
      return 7'b1000000;
    end
    return 7'b1000000;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reload(logic [7:0] v, logic [7:0] c);
    opt_val = v; opt_cmp = c; reload = 1'b1;
    @(negedge clk);
    reload = 1'b0;
    m_level = ref_level(v, c);
    chk(level == 2'(m_level), "R1 level decode", 32'(level), 32'(m_level));
    chk(dbg_off == (m_level == 2), "R7 debug_off", 32'(dbg_off), 32'(m_level == 2));
  endtask

  task automatic do_req(int md, int tg, int op, bit pr, logic [7:0] wd);
    logic [6:0] exp, act;
    string tag;
    exp = ref_out(m_level, m_busy, md, tg, op, pr, wd);
    mode = 2'(md); tgt = 2'(tg); valid = 1'b1;
    rd = (op == 0); pg = (op == 1); er = (op == 2); prot = pr; wdata = wd;
    @(negedge clk);
    valid = 1'b0; rd = 1'b0; pg = 1'b0; er = 1'b0; prot = 1'b0;
    act = {grant, berr, fault, pgerr, wperr, merase, bclr};
    if (tg < 2 && m_level == 1 && md != 0) tag = (op != 0) ? "R5 restricted write" : "R4 restricted access";
    else if (tg < 2 && m_level == 2) tag = "R7 lock treats mode as user";
    else if (tg < 2) tag = "R6 user access";
    else if (tg == 2 && m_level == 2) tag = "R8 lock option rules";
    else if (tg == 2 && m_busy && op != 0) tag = "R10 busy blocks option write";
    else if (tg == 2 && exp[1]) tag = "R9 lowering erase";
    else tag = "R11 option program";
    chk(act == exp, tag, 32'(act), 32'(exp));
    if (exp[1]) m_busy = 1;
    chk(busy == m_busy, "R10 busy flag", 32'(busy), 32'(m_busy));
  endtask

  task automatic finish_erase();
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    m_busy = 0;
    chk(busy == 1'b0, "R10 busy clears on done", 32'(busy), 32'd0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(level == 2'd1, "R2 reset level", 32'(level), 32'd1);
    chk({grant, berr, merase, busy, dbg_off} == 5'b0, "R2 reset outputs",
        32'({grant, berr, merase, busy, dbg_off}), 32'd0);
    // R2 and R3: option bytes alone do not change level
    opt_val = 8'hAA; opt_cmp = 8'h55;
    repeat (3) @(negedge clk);
    chk(level == 2'd1, "R3 no reload no change", 32'(level), 32'd1);
    do_req(1, 0, 0, 0, 8'h00);          // R4 debug read at level 1
    do_req(3, 1, 0, 0, 8'h00);          // R4 backup from boot loader
    do_req(2, 0, 2, 0, 8'h00);          // R5 erase from boot RAM
    do_req(0, 0, 1, 0, 8'h00);          // R6 user program
    do_reload(8'hAA, 8'h54);            // R1 bad complement -> 1
    do_reload(8'hFF, 8'hFF);            // R1 erased -> 1
    do_reload(8'hAA, 8'h55);            // R1 -> 0
    do_req(1, 0, 0, 0, 8'h00);          // R6-style: level 0 debug allowed
    do_req(0, 2, 1, 1, 8'h12);          // R11 level 0 -> 1 program
    do_req(0, 2, 1, 1, 8'hAA);          // R9 level 0 erase, no bkp
    do_req(0, 2, 1, 0, 8'h00);          // R10 blocked
    do_req(0, 2, 0, 0, 8'h00);          // R10 read ok
    finish_erase();
    do_reload(8'h37, 8'hC8);            // level 1
    do_req(0, 2, 1, 1, 8'hAA);          // R9 with bkp
    do_req(0, 2, 2, 0, 8'h00);          // R10 erase blocked
    finish_erase();
    do_reload(8'hCC, 8'h33);            // level 2
    do_req(1, 0, 0, 0, 8'h00);          // R7
    do_req(2, 1, 1, 0, 8'h00);          // R7
    do_req(0, 2, 2, 0, 8'h00);          // R8 erase rejected
    do_req(0, 2, 1, 1, 8'hAA);          // R8 prot program rejected
    do_req(0, 2, 1, 0, 8'h5A);          // R8 other option ok
    for (int i = 0; i < 600; i++) begin
      int r;
      r = int'($urandom_range(0, 9));
      if (r == 0) begin
        int s;
        s = int'($urandom_range(0, 4));
        case (s)
          0: do_reload(8'hAA, 8'h55);
          1: do_reload(8'hCC, 8'h33);
          2: do_reload(8'hCC, 8'h32);
          3: do_reload(8'hFF, 8'hFF);
          default: do_reload(8'($urandom), 8'($urandom));
        endcase
      end else if (r == 1 && m_busy) begin
        finish_erase();
      end else begin
        logic [7:0] wd;
        wd = ($urandom_range(0, 2) == 0) ? 8'hAA : 8'($urandom);
        do_req(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
               int'($urandom_range(0, 2)), 1'($urandom), wd);
      end
    end
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule